// File: doc/BRIEF.md
# One-Time-Programmable Store Programming Port

This block is the target side of a one-time-programmable program store while the store is in its programming mode. An external programmer has no address pins to drive. It steers the block through four mode pins and walks an internal byte pointer forward by pulsing a separate address clock. Bytes travel over an 8-bit data path: the programmer supplies them in write mode, and the block returns them in read/verify mode. The data path is split into an input, an output and an output-enable, which the pad ring combines into one bidirectional bus.

The store is organised as 16-bit words. Over the byte-wide port each word is seen as two bytes: its upper half at the even byte address and its lower half at the odd byte address that follows. A write can only clear bits. The stored byte becomes the old value ANDed with the supplied data, so an erased 1 can be programmed to 0 but never set back to 1. All pins are sampled on the block's system clock and are assumed to be synchronous to it already.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the byte pointer and the pulse counter are zero, the output enable is low, the last-byte flag is low, and every stored bit reads 1 (bytes read 8'hFF).
- R2: The mode pins, written {MD3,MD2,MD1,MD0}, decode as follows: 4'b0101 is clear, 4'b1110 is write, 4'b1100 is read/verify, and 4'b11?1 is inhibit. Any other code has no effect on the store, the pointer or the output enable.
- R3: While the clear code is present, the byte pointer and the pulse counter are both zero one clock later, whatever the address clock does.
- R4: Address-clock pulses are counted in groups of four. The pointer advances by exactly one on the falling edge of the third pulse of each group, and no other edge moves it.
- R5: Byte address 2w selects bits 15:8 of word w, and byte address 2w+1 selects bits 7:0 of word w.
- R6: When the pins go from the write code to 4'b1111 (MD0 rising), the byte at the pointer becomes its old value ANDed with data_i sampled in that cycle. Bits never go from 0 to 1.
- R7: data_oe_o is high exactly one clock after a cycle in which the pins show the read/verify code, and low otherwise. data_o is 8'h00 whenever data_oe_o is low.
- R8: While data_oe_o is high, data_o equals the stored byte at the current pointer.
- R9: The pointer stops at the last byte (2^BYTE_ADDR_W - 1) instead of wrapping. at_last_o is high exactly when the pointer is at that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which all pins are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| prg_clk_i | input | 1 | Address-advance clock from the programmer |
| mode_pins_i | input | 4 | Mode pins {MD3,MD2,MD1,MD0}; MD0 also acts as the write strobe |
| data_i | input | 8 | Byte from the bus pad, used in write mode |
| data_o | output | 8 | Byte to the bus pad in read/verify mode |
| data_oe_o | output | 1 | Pad output enable; high-impedance when low |
| at_last_o | output | 1 | Pointer is at the last byte |

## Verification
The bench builds the block with BYTE_ADDR_W = 5, giving a 32-byte store. With that size the saturating pointer and its flag can be reached in about a hundred address pulses, and a pass can still visit every byte. Pulse counts are kept at four per address step, so partial groups, a mid-group clear and the third-pulse step all line up with the default behaviour. A behavioural model in the bench, built on a byte array and integers, is compared against the outputs on every clock.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    typedef enum logic [2:0] {
        PM_IDLE,
        PM_CLEAR,
        PM_WRITE,
        PM_READ,
        PM_INHIBIT
    } pmode_e;

    // Pin order {MD3, MD2, MD1, MD0}
    localparam logic [3:0] PIN_CLEAR   = 4'b0101;
    localparam logic [3:0] PIN_WRITE   = 4'b1110;
    localparam logic [3:0] PIN_READ    = 4'b1100;
    localparam logic [3:0] PIN_STROBE_HI = 4'b1111;

    function automatic pmode_e decode_pins(input logic [3:0] pins);
        pmode_e m;
        casez (pins)
            4'b0101: m = PM_CLEAR;
            4'b1110: m = PM_WRITE;
            4'b1100: m = PM_READ;
            4'b11?1: m = PM_INHIBIT;
            default: m = PM_IDLE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_prog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] pins_i,
    output pmode_e     mode_o,
    output logic       commit_o
);

    typedef struct packed {
        logic [3:0] pins;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d      = dec_q;
        dec_d.pins = pins_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign mode_o   = decode_pins(pins_i);
    // MD0 rising out of the write code ends the strobe and commits the byte
    assign commit_o = (dec_q.pins == PIN_WRITE) && (pins_i == PIN_STROBE_HI);

endmodule

// File: rtl/otp_addr_seq.sv
module otp_addr_seq #(
    parameter int BYTE_ADDR_W     = 11,
    parameter int PULSES_PER_STEP = 4,
    parameter int STEP_PULSE      = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prg_clk_i,
    input  logic                   clear_i,
    output logic [BYTE_ADDR_W-1:0] addr_o,
    output logic                   at_last_o
);

    localparam int PH_W = (PULSES_PER_STEP > 1) ? $clog2(PULSES_PER_STEP) : 1;
    localparam logic [BYTE_ADDR_W-1:0] LAST_ADDR = {BYTE_ADDR_W{1'b1}};
    localparam logic [PH_W-1:0] PH_MAX  = PH_W'(PULSES_PER_STEP - 1);
    localparam logic [PH_W-1:0] PH_STEP = PH_W'(STEP_PULSE - 1);

    typedef struct packed {
        logic [BYTE_ADDR_W-1:0] addr;
        logic [PH_W-1:0]        phase;
        logic                   pclk;
    } seq_t;

    seq_t seq_d, seq_q;
    logic pclk_fall;

    always_comb begin
        seq_d      = seq_q;
        seq_d.pclk = prg_clk_i;
        pclk_fall  = seq_q.pclk & ~prg_clk_i;
        if (clear_i) begin
            seq_d.addr  = '0;
            seq_d.phase = '0;
        end else if (pclk_fall) begin
            seq_d.phase = (seq_q.phase == PH_MAX) ? '0 : seq_q.phase + 1'b1;
            if (seq_q.phase == PH_STEP && seq_q.addr != LAST_ADDR) begin
                seq_d.addr = seq_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr_o    = seq_q.addr;
    assign at_last_o = (seq_q.addr == LAST_ADDR);

    AST_ADDR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_o != $past(addr_o)) |-> (addr_o == $past(addr_o) + 1'b1 || addr_o == '0)); // R4

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (addr_o == '0)); // R3

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last_o && !clear_i) |=> at_last_o); // R9

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store #(
    parameter int BYTE_ADDR_W = 11,
    parameter int WORD_W      = 16,
    parameter int BYTE_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [BYTE_ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0]      wdata_i,
    output logic [BYTE_W-1:0]      rdata_o
);

    localparam int LANES  = WORD_W / BYTE_W;
    localparam int WORD_AW = BYTE_ADDR_W - 1;
    localparam int WORDS  = 1 << WORD_AW;

    logic [WORD_AW-1:0] widx;
    logic               lane_sel;
    logic [BYTE_W-1:0]  lane_rd [LANES];

    assign widx     = addr_i[BYTE_ADDR_W-1:1];
    assign lane_sel = addr_i[0];

    // lane 0 holds the upper byte of each word (even address), lane 1 the lower
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem_q [WORDS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < WORDS; i++) begin
                    mem_q[i] <= '1;
                end
            end else if (wr_i && lane_sel == 1'(g)) begin
                mem_q[widx] <= mem_q[widx] & wdata_i;
            end
        end

        assign lane_rd[g] = mem_q[widx];
    end

    assign rdata_o = lane_rd[lane_sel];

    AST_BITS_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((rdata_o & ~$past(rdata_o)) == '0) || (addr_i != $past(addr_i))); // R6

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
    import otp_prog_pkg::*;
#(
    parameter int BYTE_ADDR_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prg_clk_i,
    input  logic [3:0] mode_pins_i,
    input  logic [7:0] data_i,
    output logic [7:0] data_o,
    output logic       data_oe_o,
    output logic       at_last_o
);

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic oe;
    } port_t;

    port_t port_d, port_q;

    pmode_e                 mode;
    logic                   commit;
    logic [BYTE_ADDR_W-1:0] addr;
    logic [BYTE_W-1:0]      rdata;

    otp_mode_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_i   (mode_pins_i),
        .mode_o   (mode),
        .commit_o (commit)
    );

    otp_addr_seq #(
        .BYTE_ADDR_W     (BYTE_ADDR_W),
        .PULSES_PER_STEP (4),
        .STEP_PULSE      (3)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .prg_clk_i (prg_clk_i),
        .clear_i   (mode == PM_CLEAR),
        .addr_o    (addr),
        .at_last_o (at_last_o)
    );

    otp_byte_store #(
        .BYTE_ADDR_W (BYTE_ADDR_W),
        .WORD_W      (WORD_W),
        .BYTE_W      (BYTE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (commit),
        .addr_i  (addr),
        .wdata_i (data_i),
        .rdata_o (rdata)
    );

    always_comb begin
        port_d    = port_q;
        port_d.oe = (mode == PM_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign data_oe_o = port_q.oe;
    assign data_o    = port_q.oe ? rdata : '0;

    AST_NO_DRIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_WRITE) |=> !data_oe_o); // R7

    AST_COMMIT_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !data_oe_o); // R7

endmodule

// File: tb/otp_prog_port_tb.sv
module otp_prog_port_tb_top;

    localparam int AW   = 5;
    localparam int NB   = 1 << AW;
    localparam int LAST = NB - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prg_clk = 1'b0;
    logic [3:0] pins = 4'b1111;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       oe;
    logic       at_last;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    otp_prog_port #(.BYTE_ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .prg_clk_i   (prg_clk),
        .mode_pins_i (pins),
        .data_i      (din),
        .data_o      (dout),
        .data_oe_o   (oe),
        .at_last_o   (at_last)
    );

    // behavioural reference model
    logic [7:0] m_mem [NB];
    int         m_addr;
    int         m_ph;
    logic       m_oe;
    logic       m_pclk;
    logic [3:0] m_pins;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_ph = 0; m_oe = 1'b0; m_pclk = 1'b0; m_pins = 4'b0000;
            for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
        end else begin
            if (m_pins == 4'b1110 && pins == 4'b1111) m_mem[m_addr] = m_mem[m_addr] & din;
            if (pins == 4'b0101) begin
                m_addr = 0; m_ph = 0;
            end else if (m_pclk && !prg_clk) begin
                if (m_ph == 2 && m_addr != LAST) m_addr = m_addr + 1;
                m_ph = (m_ph + 1) % 4;
            end
            m_oe   = (pins == 4'b1100);
            m_pclk = prg_clk;
            m_pins = pins;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (oe !== m_oe) begin
                errors++;
                $display("FAIL R7 model oe: actual %0b expected %0b", oe, m_oe);
            end
            checks++;
            if (dout !== (m_oe ? m_mem[m_addr] : 8'h00)) begin
                errors++;
                $display("FAIL R8 model data: actual %02h expected %02h", dout,
                         m_oe ? m_mem[m_addr] : 8'h00);
            end
            checks++;
            if (at_last !== (m_addr == LAST)) begin
                errors++;
                $display("FAIL R9 model flag: actual %0b expected %0b", at_last, m_addr == LAST);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            prg_clk = 1'b1; wait_cyc(2);
            prg_clk = 1'b0; wait_cyc(2);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        pins = p; wait_cyc(2);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        set_pins(4'b1111);
        din = d; wait_cyc(1);
        set_pins(4'b1110);
        set_pins(4'b1111);
        din = 8'h00;
    endtask

    task automatic rd_check(input string req, input logic [7:0] exp);
        set_pins(4'b1100);
        chk(req, {7'd0, oe}, 8'h01);
        chk(req, dout, exp);
        set_pins(4'b1111);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 oe low", {7'd0, oe}, 8'h00);
        chk("R1 flag low", {7'd0, at_last}, 8'h00);
        chk("R1 data quiet", dout, 8'h00);
        rd_check("R1 erased byte", 8'hFF);

        set_pins(4'b0101);
        set_pins(4'b1111);
        wr_byte(8'h3C);
        pulse(4);
        wr_byte(8'hA5);
        pulse(4);
        wr_byte(8'h81);

        set_pins(4'b0101);
        chk("R3 clear to byte 0", {7'd0, at_last}, 8'h00);
        set_pins(4'b1100);
        chk("R5 R8 even byte", dout, 8'h3C);
        pulse(2);
        chk("R4 no step after two pulses", dout, 8'h3C);
        prg_clk = 1'b1; wait_cyc(2);
        chk("R4 no step on third rise", dout, 8'h3C);
        prg_clk = 1'b0; wait_cyc(2);
        chk("R4 step on third fall", dout, 8'hA5);
        pulse(1);
        chk("R4 fourth pulse holds", dout, 8'hA5);
        pulse(4);
        chk("R5 next word upper", dout, 8'h81);
        set_pins(4'b1111);
        chk("R7 oe drops", {7'd0, oe}, 8'h00);
        chk("R7 data quiet", dout, 8'h00);

        // back to byte 1, reprogram: AND update
        set_pins(4'b0101);
        set_pins(4'b1111);
        pulse(4);
        wr_byte(8'h0F);
        rd_check("R6 and update", 8'h05);
        wr_byte(8'hFF);
        rd_check("R6 no 0 to 1", 8'h05);

        // unrelated codes with MD0 toggling do not write
        din = 8'h00;
        set_pins(4'b0010);
        set_pins(4'b0011);
        set_pins(4'b1100);
        set_pins(4'b1101);
        rd_check("R2 no write from other codes", 8'h05);

        // clear in mid group resets pulse counter
        set_pins(4'b0101);
        set_pins(4'b1111);
        pulse(1);
        set_pins(4'b0101);
        set_pins(4'b1111);
        pulse(3);
        rd_check("R3 phase cleared", 8'h05);

        // walk to the end and beyond
        pulse(4 * (LAST + 3));
        chk("R9 flag at end", {7'd0, at_last}, 8'h01);
        rd_check("R9 last byte erased", 8'hFF);
        set_pins(4'b0101);
        chk("R3 flag cleared", {7'd0, at_last}, 8'h00);
        rd_check("R3 back at byte 0", 8'h3C);

        wait_cyc(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule